// File: doc/BRIEF.md
# Programmable Countdown Event Timer

A single-channel countdown timer with a 32-bit register interface. Software writes a 64-bit load value as two words, then sets the enable bit in a control word. On that enable the counter takes the load value. It then counts down once per clock and signals an expiry on the cycle after it reaches zero. A control bit picks between auto-reload and single expiry. In auto-reload mode the block produces one event every load+1 clocks. In single-expiry mode it fires once and then waits to be re-armed.

Each expiry sets a sticky pending flag. Software clears the flag by writing a 1 to the status word. A level interrupt output follows the pending flag while the interrupt is unmasked. Bus and counter run on one clock with one active-low reset.

Top module: `evt_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and irq_o is low.
- R2: Byte offsets: load low word 0x00, load high word 0x04, control 0x10, status 0x18. Control bit 0 is enable, bit 1 is mode (0 auto-reload, 1 single expiry) and bit 2 is interrupt unmask. The other control bits read 0. Load words read back as written. Any other offset reads 0, and writes to it change nothing.
- R3: A control write that sets bit 0 while enable is 0 loads the counter with {high,low}. With load value L, the first expiry sets the status flag L+1 clocks after that write edge.
- R4: In auto-reload mode the counter reloads on each expiry and expires again every L+1 clocks.
- R5: In single-expiry mode the timer expires exactly once. It does not expire again until enable is cleared and set again. Rewriting control with enable still 1 does not restart it.
- R6: Load writes made while the timer runs leave the current count untouched. They take effect at the next reload or start.
- R7: Writing control with bit 0 clear stops the count, and no further expiry occurs. The status flag is left as it was.
- R8: The status flag (bit 0 at 0x18) is sticky. Writing 1 to bit 0 clears it. Writing 0 has no effect.
- R9: If a clear write and an expiry fall in the same cycle, the flag stays set.
- R10: irq_o is high exactly while the status flag is set and control bit 2 is 1.
- R11: The high load word is part of the count. A load of high=1, low=0 gives no expiry within hundreds of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for bus and counter |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | AW (5) | Byte offset of the register |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
Reads are combinational. Register writes and status clears become visible at the negedge that follows the write edge. With load L, the first expiry appears L+1 clocks after the enabling write edge, and later expiries follow every L+1 clocks. The bench drives all writes from negedges and counts negedges from the write edge. It checks that the flag is still clear one clock before each due expiry and set on the due clock, so an early or late event is caught. Same-cycle clear and expiry uses a load of 0, so an expiry falls on every edge.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int OFS_LOAD   = 'h00;
  localparam int OFS_CTRL   = 'h10;
  localparam int OFS_STAT   = 'h18;
  localparam int WORD_BYTES = 4;

  // bit positions match the control word
  typedef struct packed {
    logic unmask;
    logic single;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 64,
  parameter int AW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             flag_i,
  output logic [CNT_W-1:0] load_o,
  output ctrl_t            ctrl_o,
  output logic             start_o,
  output logic             clr_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int NW = CNT_W / DW;
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_STAT = AW'(OFS_STAT);

  logic [DW-1:0] load_q [NW];
  ctrl_t         ctrl_q;
  logic          ctrl_wr;

  for (genvar w = 0; w < NW; w++) begin : g_load
    localparam logic [AW-1:0] A_W = AW'(OFS_LOAD + WORD_BYTES * w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       load_q[w] <= '0;
      else if (we_i && addr_i == A_W)    load_q[w] <= wdata_i;
    end
    assign load_o[w*DW +: DW] = load_q[w];
  end

  assign ctrl_wr = we_i && (addr_i == A_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[2:0]);
  end

  // start only on an enable edge
  assign start_o = ctrl_wr && wdata_i[0] && !ctrl_q.en;
  assign clr_o   = we_i && (addr_i == A_STAT) && wdata_i[0];
  assign ctrl_o  = ctrl_q;

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NW; w++)
      if (addr_i == AW'(OFS_LOAD + WORD_BYTES * w)) rdata_o = load_q[w];
    if (addr_i == A_CTRL) rdata_o = DW'(ctrl_q);
    if (addr_i == A_STAT) rdata_o = DW'(flag_i);
  end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             single_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             run;

  assign run      = en_i && !done_q;
  assign expire_o = run && (cnt_q == '0);
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= load_i;
      done_q <= 1'b0;
    end else if (expire_o) begin
      if (single_i) done_q <= 1'b1;
      else          cnt_q  <= load_i;
    end else if (run) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic unmask_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // expiry has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && unmask_i;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 64,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [CNT_W-1:0] load;
  logic [CNT_W-1:0] cnt;
  ctrl_t            ctrl;
  logic             start, clr, expire, flag;

  evt_timer_regs #(.DW(DW), .CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag_i  (flag),
    .load_o  (load),
    .ctrl_o  (ctrl),
    .start_o (start),
    .clr_o   (clr),
    .rdata_o (rdata_o)
  );

  evt_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .en_i     (ctrl.en),
    .single_i (ctrl.single),
    .load_i   (load),
    .expire_o (expire),
    .cnt_o    (cnt)
  );

  evt_timer_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .expire_i (expire),
    .clr_i    (clr),
    .unmask_i (ctrl.unmask),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             expire_i,
  input logic             clr_i,
  input logic             flag_i,
  input logic             irq_i,
  input logic             en_i,
  input logic             single_i,
  input logic             unmask_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] load_i
);
  assert_start_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cnt_i == $past(load_i));

  assert_auto_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && !single_i && !start_i |=> cnt_i == $past(load_i));

  assert_single_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i && single_i |=> !expire_i);

  assert_stopped_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !start_i |=> $stable(cnt_i));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i && !clr_i |=> flag_i);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !expire_i |=> !flag_i);

  assert_expiry_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> flag_i);

  assert_irq_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unmask_i |-> !irq_i);
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start),
  .expire_i (expire),
  .clr_i    (clr),
  .flag_i   (flag),
  .irq_i    (irq_o),
  .en_i     (ctrl.en),
  .single_i (ctrl.single),
  .unmask_i (ctrl.unmask),
  .cnt_i    (cnt),
  .load_i   (load)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_LO = 5'h00, A_HI = 5'h04, A_CTRL = 5'h10, A_STAT = 5'h18;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flag_is(input string req, input logic exp);
    logic [31:0] d;
    rd(A_STAT, d);
    check(req, d, {31'b0, exp});
  endtask

  task automatic prep();
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_LO, d);   check("R1 lo", d, 0);
    rd(A_HI, d);   check("R1 hi", d, 0);
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_STAT, d); check("R1 stat", d, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(A_LO, 32'hDEADBEEF);
    wr(A_HI, 32'h12345678);
    wr(A_CTRL, 32'hFFFF_FFFE);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(A_LO, d);   check("R2 lo readback", d, 32'hDEADBEEF);
    rd(A_HI, d);   check("R2 hi readback", d, 32'h12345678);
    rd(A_CTRL, d); check("R2 ctrl bits", d, 32'h6);
    rd(5'h08, d);  check("R2 unmapped", d, 0);
    rd(5'h0C, d);  check("R2 unmapped2", d, 0);
    wait_n(5);
    flag_is("R2 disabled no event", 1'b0);
    prep();
  endtask

  task automatic t_periodic();
    wr(A_LO, 32'd4); wr(A_HI, 32'd0);
    wr(A_CTRL, 32'h1);
    wait_n(4); flag_is("R3 not early", 1'b0);
    wait_n(1); flag_is("R3 first expiry", 1'b1);
    wr(A_STAT, 32'h1);
    wait_n(3); flag_is("R4 not early", 1'b0);
    wait_n(1); flag_is("R4 second expiry", 1'b1);
    wr(A_STAT, 32'h1);
    wait_n(3); flag_is("R4 not early 3", 1'b0);
    wait_n(1); flag_is("R4 third expiry", 1'b1);
    prep();
  endtask

  task automatic t_single();
    wr(A_LO, 32'd3); wr(A_HI, 32'd0);
    wr(A_CTRL, 32'h3);
    wait_n(3); flag_is("R5 not early", 1'b0);
    wait_n(1); flag_is("R5 expiry", 1'b1);
    wr(A_STAT, 32'h0); flag_is("R8 write 0 ignored", 1'b1);
    wr(A_STAT, 32'h1); flag_is("R8 clear", 1'b0);
    wait_n(20); flag_is("R5 no second expiry", 1'b0);
    wr(A_CTRL, 32'h3);
    wait_n(10); flag_is("R5 rewrite no restart", 1'b0);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h3);
    wait_n(3); flag_is("R5 rearm not early", 1'b0);
    wait_n(1); flag_is("R5 rearm expiry", 1'b1);
    prep();
  endtask

  task automatic t_load_live();
    wr(A_LO, 32'd10); wr(A_HI, 32'd0);
    wr(A_CTRL, 32'h1);
    wr(A_LO, 32'd20);
    wait_n(9); flag_is("R6 not early", 1'b0);
    wait_n(1); flag_is("R6 old count kept", 1'b1);
    wr(A_STAT, 32'h1);
    wait_n(19); flag_is("R6 new period not early", 1'b0);
    wait_n(1); flag_is("R6 new period used", 1'b1);
    prep();
  endtask

  task automatic t_race_stop();
    logic [31:0] d;
    wr(A_LO, 32'd0); wr(A_HI, 32'd0);
    wr(A_CTRL, 32'h1);
    wait_n(2);
    wr(A_STAT, 32'h1); flag_is("R9 expiry wins", 1'b1);
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h1);
    wait_n(5); flag_is("R7 stopped", 1'b0);
    rd(A_CTRL, d); check("R7 ctrl reads 0", d, 0);
    prep();
  endtask

  task automatic t_irq();
    wr(A_LO, 32'd2); wr(A_HI, 32'd0);
    wr(A_CTRL, 32'h3);
    wait_n(3);
    flag_is("R10 flag set", 1'b1);
    check("R10 masked", {31'b0, irq_o}, 0);
    wr(A_CTRL, 32'h7);
    check("R10 unmasked", {31'b0, irq_o}, 1);
    wr(A_STAT, 32'h1);
    check("R10 cleared", {31'b0, irq_o}, 0);
    wait_n(10);
    check("R10 stays low", {31'b0, irq_o}, 0);
    prep();
  endtask

  task automatic t_high();
    wr(A_LO, 32'd0); wr(A_HI, 32'd1);
    wr(A_CTRL, 32'h1);
    wait_n(300); flag_is("R11 high word counted", 1'b0);
    prep();
    wr(A_HI, 32'd0);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_ni = 1'b1;
    wait_n(1);
    t_reset();
    t_regmap();
    t_periodic();
    t_single();
    t_load_live();
    t_race_stop();
    t_irq();
    t_high();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule